// File: doc/BRIEF.md
# Dual-Bank Gated Frequency Counter

This block measures the frequency of a selected test clock by counting its rising edges over a gate of fixed length. The gate is derived from a reference clock; at the default setting it is one second of a 50 MHz reference. The block has two counters that take turns. While one counter accumulates test-clock edges for a full gate, the other is frozen, so a slow controller can read it byte by byte and then clear it. At every gate boundary the two counters swap roles. Every test-clock edge therefore lands in exactly one counter, and no cycle is lost between consecutive gates.

The gate boundary is a bank-select flag toggling in the reference domain. The flag is resynchronised into the test-clock domain before it steers the count enables. An interrupt to the controller is raised a fixed number of reference cycles after each boundary, by which time the frozen counter has settled. The interrupt stays high until the controller acknowledges it. The controller reads the bank-select bit to find the frozen bank, reads its four bytes through a port-addressed byte mux, and pulses that bank's clear strobe. A two-bit select chooses the test clock from four sources: an external input, two on-chip oscillators and the reference itself.

Top module: `freq_meter`

## Requirements
- R1: The bank-select bit toggles once every GATE_CYCLES reference cycles, exactly.
- R2: While the bank-select bit is 0, bank A counts and bank B holds its value. While it is 1, bank B counts and bank A holds its value.
- R3: Each completed gate leaves the frozen bank holding the number of test-clock rising edges in that gate, within plus or minus one of GATE_CYCLES times the reference period divided by the test period. Each bank is 32 bits wide.
- R4: The sum of several consecutive gate results is within plus or minus one of the number of test edges over their combined duration, so no edges are lost at the boundaries.
- R5: irq_o rises exactly IRQ_DELAY reference cycles after the bank-select bit changes. It stays high until irq_ack_i is sampled high, and then falls on that same reference edge.
- R6: If the acknowledge is sampled on the same reference edge that raises a new interrupt, irq_o stays high.
- R7: A one-cycle clr_a_i or clr_b_i pulse zeroes the named bank if that bank is frozen. A pulse that arrives while the bank is counting is dropped and leaves its count untouched.
- R8: Read ports 0 to 3 return bytes 0 to 3 of bank A, with port 0 the least significant byte. Ports 4 to 7 return bank B in the same order. Port 8 returns the bank-select bit in bit 0 with the other bits zero. Every other port returns zero.
- R9: src_sel_i picks the test clock: 0 is ext_clk_i, 1 is osc_a_clk_i, 2 is osc_b_clk_i, 3 is ref_clk_i.
- R10: With the reference selected as the test clock, every completed gate reports exactly GATE_CYCLES.
- R11: While rst_ni is low, irq_o is 0, the bank-select bit reads 0, and both banks read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; sets the gate and clocks the control side |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Test clock source select |
| ext_clk_i | input | 1 | External clock to measure |
| osc_a_clk_i | input | 1 | First on-chip oscillator |
| osc_b_clk_i | input | 1 | Second on-chip oscillator |
| irq_ack_i | input | 1 | Interrupt acknowledge, reference domain |
| clr_a_i | input | 1 | Clear strobe for bank A, reference domain |
| clr_b_i | input | 1 | Clear strobe for bank B, reference domain |
| rd_port_i | input | PORT_W | Read port number |
| rd_data_o | output | 8 | Byte selected by rd_port_i |
| irq_o | output | 1 | Result-ready interrupt |

## Verification
The acknowledge of a pending interrupt can fall on the same reference edge as the delayed gate event that raises the next one. To provoke this, the bench leaves one interrupt unacknowledged. It then finds the next bank toggle and, counting reference cycles from it, drives the acknowledge so that it is sampled on the exact edge where the new interrupt is due. The set must win, so irq_o is judged still high one cycle later. A separate acknowledge afterwards must then drop it.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_EXT   = 2'd0,
    SRC_OSC_A = 2'd1,
    SRC_OSC_B = 2'd2,
    SRC_REF   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fm_clk_sel.sv
module fm_clk_sel
  import freq_meter_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       ext_clk_i,
  input  logic       osc_a_clk_i,
  input  logic       osc_b_clk_i,
  input  logic       ref_clk_i,
  output logic       clk_o
);
  always_comb begin
    case (src_sel_e'(sel_i))
      SRC_EXT:   clk_o = ext_clk_i;
      SRC_OSC_A: clk_o = osc_a_clk_i;
      SRC_OSC_B: clk_o = osc_b_clk_i;
      default:   clk_o = ref_clk_i;
    endcase
  end
endmodule

// File: rtl/fm_timebase.sv
module fm_timebase #(
  parameter int unsigned GATE_CYCLES = 50_000_000,
  parameter int unsigned IRQ_DELAY   = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic bank_sel_o,
  output logic irq_o
);
  localparam int unsigned TB_W  = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam int unsigned DLY_W = $clog2(IRQ_DELAY + 1);
  localparam logic [TB_W-1:0]  TB_LAST  = TB_W'(GATE_CYCLES - 1);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(IRQ_DELAY);

  logic [TB_W-1:0]  tb_q;
  logic [DLY_W-1:0] dly_q;
  logic             gate_tick;
  logic             irq_fire;
  logic             bank_q;
  logic             irq_q;

  assign gate_tick = (tb_q == TB_LAST);
  assign irq_fire  = (dly_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q   <= '0;
      bank_q <= 1'b0;
    end else if (gate_tick) begin
      tb_q   <= '0;
      bank_q <= ~bank_q;
    end else begin
      tb_q   <= tb_q + 1'b1;
    end
  end

  // delay lets the frozen bank settle before the controller is told
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            dly_q <= '0;
    else if (gate_tick)     dly_q <= DLY_LOAD;
    else if (dly_q != '0)   dly_q <= dly_q - 1'b1;
  end

  // a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (irq_fire) irq_q <= 1'b1;
    else if (ack_i)    irq_q <= 1'b0;
  end

  assign bank_sel_o = bank_q;
  assign irq_o      = irq_q;

  p_gate_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_tick |=> (tb_q == '0) && (bank_q != $past(bank_q)));
  p_bank_steady_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_tick |=> $stable(bank_q));
  p_delay_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_tick |=> dly_q == DLY_LOAD);
  p_ack_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && ack_i && !irq_fire) |=> !irq_q);
  p_fire_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_fire && ack_i) |=> irq_q);
endmodule

// File: rtl/fm_bank.sv
module fm_bank #(
  parameter int unsigned CNT_W       = 32,
  parameter bit          ACTIVE      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             clr_tgl_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [1:0]       sync_q;
  logic             tgl_d;
  logic             en;
  logic             clr_pulse;
  logic [CNT_W-1:0] cnt_q;

  fm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clr_tgl_i, sel_i}),
    .q_o    (sync_q)
  );

  assign en        = (sync_q[0] == ACTIVE);
  assign clr_pulse = sync_q[1] ^ tgl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      tgl_d <= sync_q[1];
      if (en)             cnt_q <= cnt_q + 1'b1;
      else if (clr_pulse) cnt_q <= '0;
    end
  end

  assign cnt_o = cnt_q;

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !clr_pulse) |=> $stable(cnt_q));
  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |=> cnt_q == $past(cnt_q) + 1'b1);
  p_clear_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse && !en) |=> cnt_q == '0);
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = 50_000_000,
  parameter int unsigned IRQ_DELAY   = 100,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PORT_W      = 4
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        src_sel_i,
  input  logic              ext_clk_i,
  input  logic              osc_a_clk_i,
  input  logic              osc_b_clk_i,
  input  logic              irq_ack_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  input  logic [PORT_W-1:0] rd_port_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o
);
  localparam int unsigned BYTES = CNT_W / BYTE_W;

  logic             test_clk;
  logic             bank_sel;
  logic [1:0]       clr_req;
  logic [1:0]       clr_tgl_q;
  logic [CNT_W-1:0] cnt [2];

  assign clr_req = {clr_b_i, clr_a_i};

  fm_clk_sel u_clk_sel (
    .sel_i       (src_sel_i),
    .ext_clk_i   (ext_clk_i),
    .osc_a_clk_i (osc_a_clk_i),
    .osc_b_clk_i (osc_b_clk_i),
    .ref_clk_i   (ref_clk_i),
    .clk_o       (test_clk)
  );

  fm_timebase #(.GATE_CYCLES(GATE_CYCLES), .IRQ_DELAY(IRQ_DELAY)) u_timebase (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .ack_i      (irq_ack_i),
    .bank_sel_o (bank_sel),
    .irq_o      (irq_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    // a strobe becomes a level change that survives any test clock ratio
    always_ff @(posedge ref_clk_i or negedge rst_ni) begin
      if (!rst_ni)         clr_tgl_q[g] <= 1'b0;
      else if (clr_req[g]) clr_tgl_q[g] <= ~clr_tgl_q[g];
    end

    fm_bank #(.CNT_W(CNT_W), .ACTIVE(g != 0), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk_i     (test_clk),
      .rst_ni    (rst_ni),
      .sel_i     (bank_sel),
      .clr_tgl_i (clr_tgl_q[g]),
      .cnt_o     (cnt[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (rd_port_i == PORT_W'(b))         rd_data_o = cnt[0][BYTE_W*b +: BYTE_W];
      if (rd_port_i == PORT_W'(BYTES + b)) rd_data_o = cnt[1][BYTE_W*b +: BYTE_W];
    end
    if (rd_port_i == PORT_W'(2 * BYTES)) rd_data_o = {7'b0, bank_sel};
  end

  p_status_port_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (rd_port_i == PORT_W'(2 * BYTES)) |-> rd_data_o[7:1] == '0);
endmodule

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam real REF_P  = 20.0;
  localparam real EXT_P  = 7.0;
  localparam real OSCA_P = 13.0;
  localparam real OSCB_P = 5.0;
  localparam int  GATE   = 400;
  localparam int  DLY    = 20;

  logic       ref_clk = 0, ext_clk = 0, osc_a = 0, osc_b = 0;
  logic       rst_n = 0;
  logic [1:0] src_sel = 2'd0;
  logic       irq_ack = 0, clr_a = 0, clr_b = 0;
  logic [3:0] rd_port = 4'd8;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0, bad = 0, cyc = 0;

  always #(REF_P/2.0)  ref_clk = ~ref_clk;
  always #(EXT_P/2.0)  ext_clk = ~ext_clk;
  always #(OSCA_P/2.0) osc_a   = ~osc_a;
  always #(OSCB_P/2.0) osc_b   = ~osc_b;
  always @(negedge ref_clk) cyc++;

  freq_meter #(.GATE_CYCLES(GATE), .IRQ_DELAY(DLY)) uut (
    .ref_clk_i   (ref_clk),
    .rst_ni      (rst_n),
    .src_sel_i   (src_sel),
    .ext_clk_i   (ext_clk),
    .osc_a_clk_i (osc_a),
    .osc_b_clk_i (osc_b),
    .irq_ack_i   (irq_ack),
    .clr_a_i     (clr_a),
    .clr_b_i     (clr_b),
    .rd_port_i   (rd_port),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic bit near(input longint v, input real e);
    return ((real'(v) - e) <= 1.0) && ((e - real'(v)) <= 1.0);
  endfunction

  task automatic read_bank(input bit b, output longint v);
    v = 0;
    for (int k = 0; k < 4; k++) begin
      rd_port = 4'(b ? 4 + k : k);
      #1;
      v = v | (longint'(rd_data) << (8 * k));
    end
    rd_port = 4'd8;
    #1;
  endtask

  task automatic wait_toggle(output int t);
    bit prev;
    int guard = 0;
    rd_port = 4'd8;
    #1 prev = rd_data[0];
    do begin
      @(negedge ref_clk); #1;
      guard++;
    end while (rd_data[0] == prev && guard < 3 * GATE);
    chk(rd_data[0] != prev, "R1 bank select never toggled", rd_data[0], !prev);
    t = cyc;
  endtask

  task automatic service(input bit do_ack, input bit poke_active, output longint val);
    int guard = 0;
    bit sel, idle;
    longint again, z;
    val = 0;
    while (!irq && guard < 3 * GATE) begin @(negedge ref_clk); guard++; end
    chk(irq, "R5 interrupt never rose", irq, 1);
    rd_port = 4'd8;
    #1 sel = rd_data[0];
    idle = ~sel;  // 0 = bank A
    read_bank(idle, val);
    repeat (5) @(negedge ref_clk);
    read_bank(idle, again);
    chk(again == val, "R2 frozen bank changed", again, val);
    irq_ack = do_ack;
    if (idle) clr_b = 1; else clr_a = 1;
    if (poke_active) begin if (idle) clr_a = 1; else clr_b = 1; end
    @(negedge ref_clk);
    irq_ack = 0; clr_a = 0; clr_b = 0;
    if (do_ack) chk(irq == 0, "R5 ack did not drop interrupt", irq, 0);
    repeat (12) @(negedge ref_clk);
    read_bank(idle, z);
    chk(z == 0, "R7 clear did not zero frozen bank", z, 0);
  endtask

  task automatic test_reset();
    longint a, b;
    @(negedge ref_clk);
    chk(irq == 0, "R11 irq in reset", irq, 0);
    rd_port = 4'd8; #1;
    chk(rd_data == 0, "R11 bank select in reset", rd_data, 0);
    read_bank(0, a);
    read_bank(1, b);
    chk(a == 0, "R11 bank A in reset", a, 0);
    chk(b == 0, "R11 bank B in reset", b, 0);
    @(negedge ref_clk) rst_n = 1;
  endtask

  task automatic test_gate_timing();
    int t1, t2, k;
    longint v;
    wait_toggle(t1);
    k = 0;
    while (!irq && k < 3 * GATE) begin @(negedge ref_clk); #1; k++; end
    chk(k == DLY, "R5 interrupt delay after toggle", k, DLY);
    service(1, 0, v);
    wait_toggle(t2);
    chk(t2 - t1 == GATE, "R1 gate length", t2 - t1, GATE);
  endtask

  task automatic run_source(input logic [1:0] sel, input real per, input string tag);
    longint v, sum;
    real exp1;
    exp1 = real'(GATE) * REF_P / per;
    src_sel = sel;
    service(1, 0, v);
    service(1, 0, v);
    sum = 0;
    for (int g = 0; g < 4; g++) begin
      service(1, 0, v);
      sum += v;
      if (sel == 2'd3) chk(v == GATE, {"R10 exact self count ", tag}, v, GATE);
      else chk(near(v, exp1), {"R3 R9 gate count ", tag}, v, longint'(exp1));
    end
    chk(near(sum, 4.0 * exp1), {"R4 lossless sum ", tag}, sum, longint'(4.0 * exp1));
  endtask

  task automatic test_byte_map();
    int guard = 0;
    bit sel;
    int base;
    while (!irq && guard < 3 * GATE) begin @(negedge ref_clk); guard++; end
    rd_port = 4'd8;
    #1 sel = rd_data[0];
    base = sel ? 0 : 4;
    for (int k = 0; k < 4; k++) begin
      rd_port = 4'(base + k); #1;
      chk(rd_data == 8'((GATE >> (8 * k)) & 255), "R8 byte order", rd_data, (GATE >> (8 * k)) & 255);
    end
    rd_port = 4'd9; #1;
    chk(rd_data == 0, "R8 unused port", rd_data, 0);
    rd_port = 4'd8; #1;
    chk(rd_data[7:1] == 0, "R8 status upper bits", rd_data, sel);
    irq_ack = 1;
    if (sel) clr_a = 1; else clr_b = 1;
    @(negedge ref_clk);
    irq_ack = 0; clr_a = 0; clr_b = 0;
  endtask

  task automatic test_clear_active();
    longint v;
    real exp1;
    exp1 = real'(GATE) * REF_P / EXT_P;
    src_sel = 2'd0;
    service(1, 0, v);
    service(1, 0, v);
    service(1, 1, v);
    service(1, 0, v);
    chk(near(v, exp1), "R7 clear of counting bank ignored", v, longint'(exp1));
  endtask

  task automatic test_ack_collision();
    longint v;
    int t;
    service(0, 0, v);
    chk(irq == 1, "R5 irq held without ack", irq, 1);
    wait_toggle(t);
    chk(irq == 1, "R5 irq held across boundary", irq, 1);
    repeat (DLY - 1) @(negedge ref_clk);
    irq_ack = 1;
    @(negedge ref_clk);
    irq_ack = 0;
    #1 chk(irq == 1, "R6 new event beats ack", irq, 1);
    service(1, 0, v);
  endtask

  initial begin
    #(REF_P * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_gate_timing();
    run_source(2'd0, EXT_P, "ext");
    run_source(2'd1, OSCA_P, "osc_a");
    run_source(2'd2, OSCB_P, "osc_b");
    run_source(2'd3, REF_P, "ref");
    test_byte_map();
    test_clear_active();
    test_ack_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule